// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM with a 16-bit data bus split into two byte lanes. It takes one host request at a time, a read or a write with a two-bit lane mask, and turns it into a timed sequence of active-low chip enable, output enable, write enable and per-lane enables on the memory side. It also controls the enable of the controller's own data drivers. Every strobe is a flop output, so the memory sees clean edges with no glitches.

Reads use chip-enable control. The address is placed on the bus one cycle before chip enable falls. Read data is sampled only after both the access time from chip enable and the access time from output enable have run out. Turnaround cycles then let the memory release the bus. Writes are defined by the period in which write enable, chip enable and at least one lane enable are all low. Write enable is always the first strobe to rise, and data, address, chip enable and the lane enables stay unchanged for one more cycle. All wait lengths come from a clock-period parameter and a speed-grade parameter. With the defaults (10 ns clock, fast grade) they are 6 read-access cycles, 6 write-pulse cycles and 3 turnaround cycles.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted, req_ready is 1, rsp_done is 0, every memory strobe (mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n) is 1 and mem_dq_oe is 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from the cycle after acceptance until the cycle in which rsp_done pulses.
- R3: For a read, the cycle after acceptance drives mem_addr with every strobe high. mem_ce_n falls one cycle later, and mem_addr does not change while mem_ce_n is low.
- R4: For a read, mem_ce_n and mem_oe_n stay low together for RD+1 cycles, with RD = ceil(max(tRC, tOE) / CLK_NS). tRC is 55 ns for the fast grade and 70 ns for the slow grade; tOE is 25 ns fast and 35 ns slow. mem_dq_in is sampled at the end of the last of these cycles.
- R5: Mask bit 0 drives mem_lb_n and selects data bits 7:0. Mask bit 1 drives mem_ub_n and selects bits 15:8. A lane enable is low when its mask bit is 1. Bits of rsp_rdata in lanes that were not selected read as zero.
- R6: mem_oe_n is never low while mem_dq_oe is 1, and mem_dq_oe stays 0 for the whole of a read.
- R7: For a write with a non-zero mask, mem_dq_oe rises and mem_dq_out carries the write data from the cycle after acceptance. One cycle later mem_ce_n and mem_we_n fall, with the lane enables following the mask, and they stay low for WR = ceil(tRC / CLK_NS) cycles.
- R8: A write ends when mem_we_n rises while mem_ce_n, the lane enables, mem_addr and mem_dq_out keep their values and mem_dq_oe stays 1 for one cycle. After that cycle all strobes are high and mem_dq_oe is 0.
- R9: After the read sample, all strobes are high and mem_dq_oe is 0 for TA = ceil(max(25 ns, lane release time) / CLK_NS) cycles before the controller goes idle. The lane release time is 10 ns for the fast grade and 25 ns for the slow grade.
- R10: rsp_done pulses for one cycle, in the cycle where req_ready returns to 1. For a read, rsp_rdata holds the captured word from that cycle until the next read completes.
- R11: A write whose mask is zero is accepted and pulses rsp_done in the next cycle. No memory strobe goes low and mem_dq_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_in | input | 16 | Data from memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |

## Verification
Every strobe is registered, so a wrong state or a wrong count value shows up on the memory pins in the same cycle it occurs. It appears as a strobe edge one cycle early or late, an enable that does not match the lane mask, or a drive enable that overlaps output enable. The bench compares every pin against a per-cycle model, so such a slip is reported on the first cycle it happens. A capture done in the wrong cycle or with the wrong lane selection only shows up when rsp_done pulses. The bench's memory model therefore drives filler bytes on lanes that are not selected and returns stored words that differ between addresses.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP_ADDR,
        ST_READ_WAIT,
        ST_READ_CAPTURE,
        ST_WRITE_ACTIVE,
        ST_WRITE_RELEASE,
        ST_TURNAROUND
    } sram_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_merge.sv
module sram_lane_merge #(
    parameter int LANES = 2
) (
    input  logic [LANES*8-1:0] bus_i,
    input  logic [LANES-1:0]   sel_i,
    output logic [LANES*8-1:0] word_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_o[g*8 +: 8] = sel_i[g] ? bus_i[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int AW         = 18,
    parameter int CLK_NS     = 10,
    parameter bit FAST_GRADE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    // Timing in ns for the chosen speed grade
    localparam int T_CYCLE   = FAST_GRADE ? 55 : 70;
    localparam int T_OE_ACC  = FAST_GRADE ? 25 : 35;
    localparam int T_REL_CTL = 25;
    localparam int T_REL_BE  = FAST_GRADE ? 10 : 25;

    // Wait lengths in clocks
    localparam int RD_N  = imax(1, ceil_div(imax(T_CYCLE, T_OE_ACC), CLK_NS));
    localparam int WR_N  = imax(1, ceil_div(T_CYCLE, CLK_NS));
    localparam int TA_N  = imax(1, ceil_div(imax(T_REL_CTL, T_REL_BE), CLK_NS));
    localparam int CNT_W = $clog2(imax(imax(RD_N, WR_N), TA_N) + 1);

    typedef struct packed {
        sram_state_e         st;
        logic [CNT_W-1:0]    cnt;
        logic                is_wr;
        logic [LANES-1:0]    mask;
        logic [AW-1:0]       addr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                done;
        logic                ce_n;
        logic                oe_n;
        logic                we_n;
        logic [LANES-1:0]    be_n;
        logic                dq_oe;
    } ctrl_s;

    ctrl_s r_q, r_d;
    logic [DATA_W-1:0] lane_word;

    sram_lane_merge #(.LANES(LANES)) u_merge (
        .bus_i  (mem_dq_in),
        .sel_i  (r_q.mask),
        .word_o (lane_word)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write && (req_mask == '0)) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st    = ST_SETUP_ADDR;
                        r_d.is_wr = req_write;
                        r_d.mask  = req_mask;
                        r_d.addr  = req_addr;
                        r_d.wdata = req_wdata;
                        r_d.dq_oe = req_write;
                    end
                end
            end
            ST_SETUP_ADDR: begin
                r_d.ce_n = 1'b0;
                r_d.be_n = ~r_q.mask;
                if (r_q.is_wr) begin
                    r_d.st   = ST_WRITE_ACTIVE;
                    r_d.cnt  = CNT_W'(WR_N - 1);
                    r_d.we_n = 1'b0;
                end else begin
                    r_d.st   = ST_READ_WAIT;
                    r_d.cnt  = CNT_W'(RD_N - 1);
                    r_d.oe_n = 1'b0;
                end
            end
            ST_READ_WAIT: begin
                if (r_q.cnt == '0) r_d.st  = ST_READ_CAPTURE;
                else               r_d.cnt = r_q.cnt - 1'b1;
            end
            ST_READ_CAPTURE: begin
                r_d.rdata = lane_word;
                r_d.st    = ST_TURNAROUND;
                r_d.cnt   = CNT_W'(TA_N - 1);
                r_d.ce_n  = 1'b1;
                r_d.oe_n  = 1'b1;
                r_d.be_n  = '1;
            end
            ST_TURNAROUND: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WRITE_ACTIVE: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_WRITE_RELEASE;
                    r_d.we_n = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WRITE_RELEASE: begin
                r_d.st    = ST_IDLE;
                r_d.done  = 1'b1;
                r_d.ce_n  = 1'b1;
                r_d.be_n  = '1;
                r_d.dq_oe = 1'b0;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.ce_n <= 1'b1;
            r_q.oe_n <= 1'b1;
            r_q.we_n <= 1'b1;
            r_q.be_n <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign rsp_done   = r_q.done;
    assign rsp_rdata  = r_q.rdata;
    assign mem_addr   = r_q.addr;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_lb_n   = r_q.be_n[0];
    assign mem_ub_n   = r_q.be_n[LANES-1];
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_done,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_ub_n,
    input logic          mem_lb_n,
    input logic [15:0]   mem_dq_out,
    input logic          mem_dq_oe
);
    a_r6_no_oe_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && mem_dq_oe));

    a_r3_addr_settled_at_ce: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> $stable(mem_addr));

    a_r7_we_window: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe && mem_oe_n && !(mem_ub_n && mem_lb_n)));

    a_r8_we_rises_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr)
                             && $stable(mem_dq_out) && $stable({mem_ub_n, mem_lb_n})));

    a_r8_ce_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> (mem_we_n && $past(mem_we_n)));

    a_r10_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_ub_n   (mem_ub_n),
    .mem_lb_n   (mem_lb_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
    localparam int AW     = 18;
    localparam int CLK_NS = 10;
    localparam int RD = (55 + CLK_NS - 1) / CLK_NS;   // fast grade: max(55,25)
    localparam int WR = (55 + CLK_NS - 1) / CLK_NS;
    localparam int TA = (25 + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          req_ready, rsp_done;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0]   mem_dq_out, mem_dq_in;

    sram_lane_ctrl #(.AW(AW), .CLK_NS(CLK_NS), .FAST_GRADE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // Behavioural memory: stored words plus filler on lanes not driven
    logic [15:0] sram [0:63];
    logic [15:0] gold [0:63];
    initial for (int i = 0; i < 64; i++) begin sram[i] = '0; gold[i] = '0; end

    assign mem_dq_in = {(!mem_ce_n && !mem_oe_n && !mem_ub_n) ? sram[mem_addr[5:0]][15:8] : 8'hA5,
                        (!mem_ce_n && !mem_oe_n && !mem_lb_n) ? sram[mem_addr[5:0]][7:0]  : 8'h5A};

    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n && mem_dq_oe) begin
            if (!mem_lb_n) sram[mem_addr[5:0]][7:0]  = mem_dq_out[7:0];
            if (!mem_ub_n) sram[mem_addr[5:0]][15:8] = mem_dq_out[15:8];
        end
    end

    // Cycle reference model: k counts cycles since acceptance
    int          m_k = 0;
    int          m_op = 0;      // 0 read, 1 write, 2 zero-mask write
    logic [AW-1:0] m_a = '0;
    logic [15:0] m_d = '0, m_exp = '0;
    logic [1:0]  m_m = '0;
    bit          m_acc = 1'b0;

    function automatic int last_k(input int op);
        if (op == 0) return RD + 3 + TA;
        if (op == 1) return WR + 3;
        return 1;
    endfunction

    always @(posedge clk) begin
        m_acc = 1'b0;
        if (!rst_n) begin
            m_k = 0;
        end else if (m_k == 0 || m_k == last_k(m_op)) begin
            if (req_valid) begin
                m_acc = 1'b1;
                m_a = req_addr; m_d = req_wdata; m_m = req_mask; m_k = 1;
                if (req_write && req_mask == 2'b00) begin
                    m_op = 2;
                end else if (req_write) begin
                    m_op = 1;
                    if (req_mask[0]) gold[req_addr[5:0]][7:0]  = req_wdata[7:0];
                    if (req_mask[1]) gold[req_addr[5:0]][15:8] = req_wdata[15:8];
                end else begin
                    m_op = 0;
                    m_exp = {req_mask[1] ? gold[req_addr[5:0]][15:8] : 8'h00,
                             req_mask[0] ? gold[req_addr[5:0]][7:0]  : 8'h00};
                end
            end else begin
                m_k = 0;
            end
        end else begin
            m_k = m_k + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic e_rdy, e_done, e_ce, e_oe, e_we, e_doe;
            logic [1:0] e_be;
            string tag;
            bit busy;
            e_rdy = 1; e_done = 0; e_ce = 1; e_oe = 1; e_we = 1; e_doe = 0; e_be = 2'b11;
            tag = "R2"; busy = 0;
            if (m_k != 0) begin
                if (m_op == 0) begin
                    if (m_k == 1) begin e_rdy = 0; tag = "R3"; busy = 1; end
                    else if (m_k <= RD + 2) begin e_rdy = 0; e_ce = 0; e_oe = 0; e_be = ~m_m; tag = "R4"; busy = 1; end
                    else if (m_k <= RD + 2 + TA) begin e_rdy = 0; tag = "R9"; busy = 1; end
                    else begin e_done = 1; tag = "R10"; end
                end else if (m_op == 1) begin
                    if (m_k == 1) begin e_rdy = 0; e_doe = 1; tag = "R7"; busy = 1; end
                    else if (m_k <= WR + 1) begin e_rdy = 0; e_ce = 0; e_we = 0; e_be = ~m_m; e_doe = 1; tag = "R7"; busy = 1; end
                    else if (m_k == WR + 2) begin e_rdy = 0; e_ce = 0; e_be = ~m_m; e_doe = 1; tag = "R8"; busy = 1; end
                    else begin e_done = 1; tag = "R10"; end
                end else begin
                    e_done = 1; tag = "R11";
                end
            end
            chk({req_ready, rsp_done, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe}
                == {e_rdy, e_done, e_ce, e_oe, e_we, e_be, e_doe}, tag,
                {24'h0, req_ready, rsp_done, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe},
                {24'h0, e_rdy, e_done, e_ce, e_oe, e_we, e_be, e_doe});
            if (busy) chk(mem_addr == m_a, (m_op == 0) ? "R3 addr" : "R7 addr", 32'(mem_addr), 32'(m_a));
            if (e_doe) chk(mem_dq_out == m_d, "R8 wdata", 32'(mem_dq_out), 32'(m_d));
            if (m_op == 0 && e_done) chk(rsp_rdata == m_exp, "R5 rdata", 32'(rsp_rdata), 32'(m_exp));
            chk(!(!mem_oe_n && mem_dq_oe), "R6 overlap", {31'h0, mem_dq_oe}, 32'h0);
        end
    end

    task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
        do begin @(posedge clk); #1; end while (!m_acc);
        req_valid = 1'b0;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk({req_ready, rsp_done, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe}
            == 8'b1011_1110, "R1 reset",
            {24'h0, req_ready, rsp_done, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe},
            32'h0000_00BE);
        rst_n = 1'b1;
        do_op(1, 18'h20005, 16'h1234, 2'b11);   // R7/R8 full write
        do_op(0, 18'h20005, 16'h0000, 2'b11);   // R4/R5 full read
        do_op(1, 18'h20005, 16'hABCD, 2'b01);   // low lane only
        do_op(0, 18'h20005, 16'h0000, 2'b10);   // R5 upper lane
        do_op(0, 18'h20005, 16'h0000, 2'b01);   // R5 lower lane
        do_op(1, 18'h20005, 16'hFFFF, 2'b00);   // R11 no-op write
        do_op(1, 18'h20005, 16'hEEEE, 2'b00);   // R11 back to back
        do_op(0, 18'h20005, 16'h0000, 2'b11);   // R11 content unchanged
        do_op(1, 18'h00009, 16'h5500, 2'b10);   // upper lane write
        do_op(0, 18'h00009, 16'h0000, 2'b11);
        for (int i = 0; i < 20; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            do_op(1, a, 16'($urandom), 2'($urandom));
            do_op(0, a, 16'h0, 2'($urandom));
        end
        repeat (RD + TA + 8) @(negedge clk);
        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finished = 1'b1;
        report();
        $finish;
    end
endmodule